// File: doc/BRIEF.md
# Cluster Coherency Register Block

This block is the memory-mapped register file that sits in front of the snoop control logic of a small multiprocessor cluster. It decodes a 256-byte window on a simple register bus with separate read and write strobes. Three registers live there: a one-bit coherency enable, a read-only configuration word built from the number of cores in the cluster, and a 32-bit power status word holding one byte per core. Software may touch the status word a byte, a halfword or a word at a time, starting at any of its four byte offsets.

Everything else in the window reads as zero and ignores writes. That includes the invalidate-all register, the two address-filter registers and the two access-control registers. The block has two resets. The bus-domain reset `rst_n` clears only the enable bit. The power-on reset `por_n` also clears the status word.

The bus has no back-pressure. A write takes effect at the clock edge that samples `bus_wr`. Read data is registered and appears on the cycle after `bus_rd` is sampled. `bus_rdata` then holds that value until the next read.

Top module: `coh_cluster_regs`

## Requirements
- R1: A write to offset 0x00 stores bit 0 of the write data as the enable bit. A read of 0x00 returns that bit in bit 0, with bits 31:1 zero.
- R2: A read of offset 0x04 returns ((2^N - 1) << 4) | (N - 1), where N is the core-count parameter (1 to 4, default 1). Writes to 0x04 change nothing.
- R3: A write at offset 0x08+k (k = 0..3) replaces the status bits under the size mask shifted left by 8*k. The size mask is 0xFF for size code 1, 0xFFFF for code 2 and 0xFFFFFFFF for code 4. All other status bits keep their value.
- R4: A read at offset 0x08+k returns the status word shifted right by 8*k, with zeros filled in at the top.
- R5: Write bits shifted beyond bit 31 of the status word are dropped and never wrap to the low bits.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54, and every other undecoded offset, read as zero. Writes to them change no register.
- R7: A write whose `bus_size` is not 1, 2 or 4 changes no register.
- R8: Asserting `rst_n` low clears the enable bit and leaves the status word unchanged.
- R9: Asserting `por_n` low clears the enable bit, the status word and the read data.
- R10: Read data is valid one cycle after `bus_rd` and holds while `bus_rd` is low. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| rst_n | input | 1 | Bus reset, active low, asynchronous; clears enable bit only |
| bus_addr | input | 8 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is a write that starts high in the status word, where the shifted size mask runs past bit 31. A word or halfword write at offset 0x0B must change only the top byte and drop the rest of the data. The stimulus table first fills the status word with a distinct pattern in every byte. It then issues wide writes at the upper offsets and reads the whole word back, so that any wrap into the low bytes or any spill into a neighbouring lane shows up. Only after that does the bench pulse the bus reset, to confirm the status pattern survives it.

// File: rtl/coh_regs_pkg.sv
package coh_regs_pkg;
  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_CONFIG = 8'h04;
  localparam logic [5:0] STATUS_WORD_IDX = 6'h02; // 0x08..0x0B

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction
endpackage

// File: rtl/coh_lane_mask.sv
module coh_lane_mask
  import coh_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(DATA_W / 8)
) (
  input  logic [2:0]        size,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] base;
  logic [LANE_W+2:0] shamt;

  always_comb begin
    unique case (size)
      SZ_BYTE: base = DATA_W'(8'hFF);
      SZ_HALF: base = DATA_W'(16'hFFFF);
      default: base = '1;
    endcase
    shamt = {lane, 3'b000};
    // bits pushed past the MSB fall off: no wrap
    mask  = base << shamt;
    data  = (wdata & base) << shamt;
  end
endmodule

// File: rtl/coh_status_reg.sv
module coh_status_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              we,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] status
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) status <= '0;
    else if (we) status <= (status & ~mask) | (data & mask);
  end

  // R3
  lane_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    we |=> (((status ^ $past(status)) & ~$past(mask)) == '0));

  // R7
  status_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !we |=> $stable(status));
endmodule

// File: rtl/coh_enable_reg.sv
module coh_enable_reg (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic we,
  input  logic wbit,
  output logic enable
);
  logic any_rst_n;
  assign any_rst_n = por_n & rst_n;

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) enable <= 1'b0;
    else if (we) enable <= wbit;
  end

  // R7
  enable_idle_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    !we |=> $stable(enable));
endmodule

// File: rtl/coh_read_mux.sv
module coh_read_mux
  import coh_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] CFG_WORD = '0,
  localparam int LANE_W = $clog2(DATA_W / 8)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              enable,
  input  logic [DATA_W-1:0] status,
  output logic              hit,
  output logic [DATA_W-1:0] value
);
  logic [LANE_W+2:0] shamt;

  always_comb begin
    shamt = {addr[LANE_W-1:0], 3'b000};
    hit   = 1'b1;
    value = '0;
    if (addr == ADDR_W'(OFF_ENABLE)) value = DATA_W'(enable);
    else if (addr == ADDR_W'(OFF_CONFIG)) value = CFG_WORD;
    else if (addr[ADDR_W-1:LANE_W] == (ADDR_W-LANE_W)'(STATUS_WORD_IDX))
      value = status >> shamt;
    else hit = 1'b0;
  end
endmodule

// File: rtl/coh_cluster_regs.sv
module coh_cluster_regs
  import coh_regs_pkg::*;
#(
  parameter int N_CORES = 1,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'((((1 << N_CORES) - 1) << 4) | (N_CORES - 1));

  initial begin
    core_count_chk: assert (N_CORES >= 1 && N_CORES <= 4);
  end

  logic              wr_ok, we_enable, we_status, rd_hit;
  logic [DATA_W-1:0] st_mask, st_data, status, rd_value;
  logic              enable;

  assign wr_ok     = bus_wr && size_ok(bus_size);
  assign we_enable = wr_ok && (bus_addr == ADDR_W'(OFF_ENABLE));
  assign we_status = wr_ok &&
    (bus_addr[ADDR_W-1:LANE_W] == (ADDR_W-LANE_W)'(STATUS_WORD_IDX));

  coh_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .size(bus_size), .lane(bus_addr[LANE_W-1:0]), .wdata(bus_wdata),
    .mask(st_mask), .data(st_data)
  );

  coh_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .por_n(por_n), .we(we_status),
    .mask(st_mask), .data(st_data), .status(status)
  );

  coh_enable_reg u_enable (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .we(we_enable), .wbit(bus_wdata[0]), .enable(enable)
  );

  coh_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_WORD(CFG_WORD)) u_rmux (
    .addr(bus_addr), .enable(enable), .status(status),
    .hit(rd_hit), .value(rd_value)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_value;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !bus_rd |=> $stable(bus_rdata));

  // R6
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && !rd_hit) |=> (bus_rdata == '0));

  // R1
  enable_rd_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && bus_addr == ADDR_W'(OFF_ENABLE)) |=> (bus_rdata[DATA_W-1:1] == '0));

  // R2
  config_rd_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && bus_addr == ADDR_W'(OFF_CONFIG)) |=> (bus_rdata == CFG_WORD));
endmodule

// File: tb/coh_cluster_regs_bench.sv
`timescale 1ns/1ps
module coh_cluster_regs_bench;
  localparam int NC = 1;
  localparam logic [31:0] CFG_EXP = 32'((((1 << NC) - 1) << 4) | (NC - 1));

  logic        clk = 0, por_n = 0, rst_n = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  coh_cluster_regs #(.N_CORES(NC)) u_coh_cluster_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {req[79:76], wr[75], addr[74:67], size[66:64], wdata[63:32], exp[31:0]}
  localparam int NV = 37;
  localparam logic [79:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0, 8'h00, 3'd4, 32'h0,        32'h0},         // R1 reset value
    {4'd1, 1'b1, 8'h00, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd1, 1'b0, 8'h00, 3'd4, 32'h0,        32'h1},         // R1
    {4'd1, 1'b1, 8'h00, 3'd4, 32'h2,        32'h0},
    {4'd1, 1'b0, 8'h00, 3'd4, 32'h0,        32'h0},         // R1 bit0 only
    {4'd1, 1'b1, 8'h00, 3'd1, 32'h1,        32'h0},
    {4'd2, 1'b0, 8'h04, 3'd4, 32'h0,        CFG_EXP},       // R2
    {4'd2, 1'b1, 8'h04, 3'd4, 32'hFFFF,     32'h0},
    {4'd2, 1'b0, 8'h04, 3'd4, 32'h0,        CFG_EXP},       // R2 read-only
    {4'd3, 1'b1, 8'h08, 3'd4, 32'h11223344, 32'h0},
    {4'd3, 1'b0, 8'h08, 3'd4, 32'h0,        32'h11223344},  // R3
    {4'd4, 1'b0, 8'h09, 3'd4, 32'h0,        32'h00112233},  // R4
    {4'd4, 1'b0, 8'h0A, 3'd1, 32'h0,        32'h00001122},  // R4
    {4'd4, 1'b0, 8'h0B, 3'd2, 32'h0,        32'h00000011},  // R4
    {4'd3, 1'b1, 8'h09, 3'd1, 32'hAAAAAAAA, 32'h0},
    {4'd3, 1'b0, 8'h08, 3'd4, 32'h0,        32'h1122AA44},  // R3 byte lane 1
    {4'd3, 1'b1, 8'h0A, 3'd2, 32'h0000BEEF, 32'h0},
    {4'd3, 1'b0, 8'h08, 3'd4, 32'h0,        32'hBEEFAA44},  // R3 half at 2
    {4'd5, 1'b1, 8'h0B, 3'd4, 32'h12345678, 32'h0},
    {4'd5, 1'b0, 8'h08, 3'd4, 32'h0,        32'h78EFAA44},  // R5 no wrap
    {4'd5, 1'b1, 8'h0B, 3'd2, 32'h0000CDAB, 32'h0},
    {4'd5, 1'b0, 8'h08, 3'd4, 32'h0,        32'hABEFAA44},  // R5
    {4'd7, 1'b1, 8'h08, 3'd3, 32'h0,        32'h0},
    {4'd7, 1'b1, 8'h08, 3'd0, 32'h0,        32'h0},
    {4'd7, 1'b1, 8'h09, 3'd7, 32'h0,        32'h0},
    {4'd7, 1'b0, 8'h08, 3'd4, 32'h0,        32'hABEFAA44},  // R7 status kept
    {4'd7, 1'b1, 8'h00, 3'd3, 32'h0,        32'h0},
    {4'd7, 1'b0, 8'h00, 3'd4, 32'h0,        32'h1},         // R7 enable kept
    {4'd6, 1'b1, 8'h0C, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, 1'b1, 8'h40, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, 1'b1, 8'h54, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, 1'b1, 8'h01, 3'd1, 32'h0,        32'h0},
    {4'd6, 1'b0, 8'h0C, 3'd4, 32'h0,        32'h0},         // R6
    {4'd6, 1'b0, 8'h44, 3'd4, 32'h0,        32'h0},         // R6
    {4'd6, 1'b0, 8'h50, 3'd4, 32'h0,        32'h0},         // R6
    {4'd6, 1'b0, 8'h08, 3'd4, 32'h0,        32'hABEFAA44},  // R6 no side effect
    {4'd6, 1'b0, 8'h00, 3'd4, 32'h0,        32'h1}          // R6 no side effect
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_size = 3'd4;
    @(negedge clk);
    bus_rd = 0;
    q = bus_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    check("R9 reset rdata", bus_rdata, 32'h0);
    por_n = 1; rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][75]) do_wr(VEC[i][74:67], VEC[i][66:64], VEC[i][63:32]);
      else begin
        do_rd(VEC[i][74:67], q);
        check($sformatf("R%0d vector %0d", VEC[i][79:76], i), q, VEC[i][31:0]);
      end
    end

    // R10: read data holds with no strobe
    repeat (4) @(negedge clk);
    check("R10 hold", bus_rdata, 32'h1);

    // R10: simultaneous read and write returns old value
    do_wr(8'h08, 3'd1, 32'hFF);
    @(negedge clk);
    bus_rd = 1; bus_wr = 1; bus_addr = 8'h08; bus_size = 3'd4; bus_wdata = 32'h55;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    check("R10 read before write", bus_rdata, 32'hABEFAAFF);
    do_rd(8'h08, q);
    check("R10 write landed", q, 32'h00000055);

    // R8: bus reset clears enable only
    do_wr(8'h09, 3'd2, 32'h0000C0DE);
    do_wr(8'h00, 3'd4, 32'h1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    do_rd(8'h00, q);
    check("R8 enable cleared", q, 32'h0);
    do_rd(8'h08, q);
    check("R8 status kept", q, 32'h00C0DE55);

    // R9: power-on reset clears all
    do_wr(8'h00, 3'd4, 32'h1);
    @(negedge clk); por_n = 0;
    @(negedge clk);
    check("R9 rdata cleared", bus_rdata, 32'h0);
    por_n = 1;
    do_rd(8'h08, q);
    check("R9 status cleared", q, 32'h0);
    do_rd(8'h00, q);
    check("R9 enable cleared", q, 32'h0);
    do_rd(8'h04, q);
    check("R2 after reset", q, CFG_EXP);

    finish_run();
  end
endmodule